// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches one port of eight general-purpose inputs and raises a single interrupt line when a programmed trigger condition is seen on any pin that software has enabled. Each pin can be set to trigger on a rising edge, a falling edge, either edge, a high level or a low level. The inputs are expected to be synchronous to `clk` already.

Software controls the port through a small word bus. It writes a trigger-type word, an enable word and a write-one-to-clear word, and it reads a status word. The enable word can also be updated through a masked alias, so one pin's enable can change without a read-modify-write. Each pin keeps a small history machine with three states: UNARMED (no valid previous sample), SEEN_LOW and SEEN_HIGH. Every cycle the machine moves to SEEN_LOW or SEEN_HIGH according to the current pin value. A change to that pin's trigger type sends it back to UNARMED. An edge is reported only on the SEEN_LOW to high transition or the SEEN_HIGH to low transition. Leaving UNARMED never reports an edge. Edge status is sticky until it is cleared. Level status is recomputed every cycle from the pin.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, the status, enable and type words read as zero and `irq_out` is low.
- R2: In the type word, bit n is the polarity of pin n (1 selects high or rising), bit n+8 selects edge mode and bit n+16 selects both edges. The codes are rising 0x000101, falling 0x000100, both 0x010100, high 0x000001 and low 0x000000, each shifted left by n. The type word reads back as written.
- R3: In rising-edge mode, a status bit sets in the cycle after its pin goes from low to high. A fall does not set it.
- R4: In falling-edge mode, a status bit sets in the cycle after its pin goes from high to low. A rise does not set it.
- R5: In both-edges mode, a status bit sets in the cycle after either transition of its pin.
- R6: In level mode, a status bit equals the programmed level condition of its pin, one cycle later. A clear write has no effect while the condition still holds.
- R7: An edge-mode status bit stays set until a 1 is written to its bit at offset 0x70. Zero bits in that write have no effect. If a new edge and a clear fall in the same cycle, the bit stays set.
- R8: The enable word at offset 0x50 is written whole. At offset 0xD0, bits [15:8] act as a per-pin mask and bits [7:0] as the new values. Enable bits whose mask bit is 0 keep their value.
- R9: `irq_out` is high exactly when some pin has both its status bit and its enable bit set.
- R10: A type write that changes a pin's three fields clears that pin's status in the next cycle and returns its history machine to UNARMED. A pin transition right after the change is not reported. Pins whose fields are unchanged keep their status.
- R11: The status word is read at offset 0x40 and ignores writes. The clear register and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS (8) | Synchronous GPIO input levels |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Port interrupt |

## Verification
One port-wide configuration mixes a rising pin, a falling pin, a both-edges pin, a high-level pin and low-level pins. Each pin pattern is then applied to all of them together, so a single status read shows whether each mode separates rises from falls. Clear writes are issued while a level condition still holds, and again in the same cycle as a fresh rising edge, which tells sticky edge status apart from level-following status. A rising-edge type is programmed on a low pin that goes high right after the write. This checks that the UNARMED state suppresses a false edge that stale history would report. Writes through the masked alias with set, cleared and zero mask bits show which enable bits may move.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register offsets (byte addresses on the word bus)
    localparam logic [7:0] OFS_STATUS  = 8'h40;
    localparam logic [7:0] OFS_ENABLE  = 8'h50;
    localparam logic [7:0] OFS_TYPE    = 8'h60;
    localparam logic [7:0] OFS_CLEAR   = 8'h70;
    localparam logic [7:0] OFS_EN_MASK = 8'hD0;

    // Spacing between the polarity, edge and both-edge bytes of the type word
    localparam int FIELD_STRIDE = 8;

    // Per-pin history of the last sampled level
    typedef enum logic [1:0] {
        HS_UNARMED   = 2'd0,
        HS_SEEN_LOW  = 2'd1,
        HS_SEEN_HIGH = 2'd2
    } hist_state_e;

    // Which register the bus address selects
    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_TYPE   = 3'd3,
        SEL_CLEAR  = 3'd4,
        SEL_ENMASK = 3'd5
    } reg_sel_e;

    // Trigger configuration for one pin
    typedef struct packed {
        logic both_m;
        logic edge_m;
        logic pol;
    } trig_cfg_t;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NPINS-1:0]  sts,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  edge_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  type_chg,
    output logic [NPINS-1:0]  clr_pulse
);

    localparam int TYPE_W = 3 * FIELD_STRIDE;

    reg_sel_e sel;

    // Address decode
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_STATUS):  sel = SEL_STATUS;
            ADDR_W'(OFS_ENABLE):  sel = SEL_ENABLE;
            ADDR_W'(OFS_TYPE):    sel = SEL_TYPE;
            ADDR_W'(OFS_CLEAR):   sel = SEL_CLEAR;
            ADDR_W'(OFS_EN_MASK): sel = SEL_ENMASK;
            default:              sel = SEL_NONE;
        endcase
    end

    logic wr_en_full, wr_en_mask, wr_type, wr_clr;
    assign wr_en_full = bus_wr && (sel == SEL_ENABLE);
    assign wr_en_mask = bus_wr && (sel == SEL_ENMASK);
    assign wr_type    = bus_wr && (sel == SEL_TYPE);
    assign wr_clr     = bus_wr && (sel == SEL_CLEAR);

    logic [NPINS-1:0] new_pol, new_edge, new_both, msk_bits, msk_vals;
    assign new_pol  = bus_wdata[0 +: NPINS];
    assign new_edge = bus_wdata[FIELD_STRIDE +: NPINS];
    assign new_both = bus_wdata[2*FIELD_STRIDE +: NPINS];
    assign msk_vals = bus_wdata[0 +: NPINS];
    assign msk_bits = bus_wdata[FIELD_STRIDE +: NPINS];

    // Per-pin field comparison for the type-change pulse
    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_chg
            trig_cfg_t old_cfg, new_cfg;
            assign old_cfg = '{both_m: both_q[gi], edge_m: edge_q[gi], pol: pol_q[gi]};
            assign new_cfg = '{both_m: new_both[gi], edge_m: new_edge[gi], pol: new_pol[gi]};
            assign type_chg[gi] = wr_type && (old_cfg != new_cfg);
        end
    endgenerate

    assign clr_pulse = wr_clr ? bus_wdata[0 +: NPINS] : '0;

    // Enable register: full write or masked alias
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en_full) begin
            en_q <= bus_wdata[0 +: NPINS];
        end else if (wr_en_mask) begin
            en_q <= (en_q & ~msk_bits) | (msk_vals & msk_bits);
        end
    end

    // Type register held as three per-pin vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edge_q <= '0;
            both_q <= '0;
        end else if (wr_type) begin
            pol_q  <= new_pol;
            edge_q <= new_edge;
            both_q <= new_both;
        end
    end

    // Read mux
    logic [FIELD_STRIDE-1:0] pol_pad, edge_pad, both_pad;
    assign pol_pad  = FIELD_STRIDE'(pol_q);
    assign edge_pad = FIELD_STRIDE'(edge_q);
    assign both_pad = FIELD_STRIDE'(both_q);

    always_comb begin
        unique case (sel)
            SEL_STATUS: bus_rdata = DATA_W'(sts);
            SEL_ENABLE: bus_rdata = DATA_W'(en_q);
            SEL_TYPE:   bus_rdata = DATA_W'({both_pad, edge_pad, pol_pad});
            default:    bus_rdata = '0;
        endcase
    end

    // Data bits no register uses
    logic wdata_unused;
    assign wdata_unused = ^bus_wdata[DATA_W-1:TYPE_W];

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic edge_m,
    input  logic both_m,
    input  logic clr,
    input  logic chg,
    output logic sts
);

    hist_state_e state_q, state_d;
    logic rise, fall, hit, lvl_cond;

    // Next-state logic
    always_comb begin
        if (chg) begin
            state_d = HS_UNARMED;
        end else if (pin) begin
            state_d = HS_SEEN_HIGH;
        end else begin
            state_d = HS_SEEN_LOW;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_UNARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Edge detection from the current state
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            HS_UNARMED:   begin rise = 1'b0; fall = 1'b0; end
            HS_SEEN_LOW:  rise = pin;
            HS_SEEN_HIGH: fall = !pin;
            default:      begin rise = 1'b0; fall = 1'b0; end
        endcase
    end

    assign hit      = both_m ? (rise | fall) : (pol ? rise : fall);
    assign lvl_cond = pol ? pin : !pin;

    // Status output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (chg) begin
            sts <= 1'b0;
        end else if (!edge_m) begin
            sts <= lvl_cond;
        end else begin
            sts <= (sts & !clr) | hit;
        end
    end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] sts,
    input  logic [NPINS-1:0] en,
    output logic             irq
);

    assign irq = |(sts & en);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [NPINS-1:0] sts_q, en_q, pol_q, edge_q, both_q, type_chg, clr_pulse;

    gpio_irq_regs #(
        .NPINS (NPINS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sts      (sts_q),
        .bus_rdata(bus_rdata),
        .en_q     (en_q),
        .pol_q    (pol_q),
        .edge_q   (edge_q),
        .both_q   (both_q),
        .type_chg (type_chg),
        .clr_pulse(clr_pulse)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NPINS; gp++) begin : g_pin
            gpio_irq_pin u_pin (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (pin_in[gp]),
                .pol   (pol_q[gp]),
                .edge_m(edge_q[gp]),
                .both_m(both_q[gp]),
                .clr   (clr_pulse[gp]),
                .chg   (type_chg[gp]),
                .sts   (sts_q[gp])
            );
        end
    endgenerate

    gpio_irq_merge #(.NPINS(NPINS)) u_merge (
        .sts(sts_q),
        .en (en_q),
        .irq(irq_out)
    );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  pin_in,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  sts,
    input logic [NPINS-1:0]  en,
    input logic [NPINS-1:0]  pol,
    input logic [NPINS-1:0]  edge_sel,
    input logic [NPINS-1:0]  chg,
    input logic [NPINS-1:0]  clr,
    input logic              irq_out
);

    // R9: interrupt equals any enabled status
    a_r9_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(sts & en));

    genvar gc;
    generate
        for (gc = 0; gc < NPINS; gc++) begin : g_chk
            // R7: edge status holds without a clear or type change
            a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_sel[gc] && sts[gc] && !clr[gc] && !chg[gc]) |=> sts[gc]);

            // R6: level status follows the condition one cycle later
            a_r6_level_track: assert property (@(posedge clk) disable iff (!rst_n)
                (!edge_sel[gc] && !chg[gc]) |=>
                    (sts[gc] == ($past(pol[gc]) ? $past(pin_in[gc]) : !$past(pin_in[gc]))));

            // R10: a type change clears the status
            a_r10_chg_clear: assert property (@(posedge clk) disable iff (!rst_n)
                chg[gc] |=> !sts[gc]);

            // R8: masked alias leaves unmasked enables alone
            a_r8_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == ADDR_W'(OFS_EN_MASK) && !bus_wdata[FIELD_STRIDE + gc])
                    |=> (en[gc] == $past(en[gc])));
        end
    endgenerate

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .NPINS (NPINS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sts      (sts_q),
    .en       (en_q),
    .pol      (pol_q),
    .edge_sel (edge_q),
    .chg      (type_chg),
    .clr      (clr_pulse),
    .irq_out  (irq_out)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;

    localparam int NPINS  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [7:0] A_STS  = 8'h40;
    localparam logic [7:0] A_EN   = 8'h50;
    localparam logic [7:0] A_TYP  = 8'h60;
    localparam logic [7:0] A_CLR  = 8'h70;
    localparam logic [7:0] A_MSK  = 8'hD0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pin_in = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_out;

    always #2 clk = ~clk;

    gpio_irq_port #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_out  (irq_out)
    );

    // Scoreboard
    logic [31:0] exp_q[$];
    bit          kind_q[$];
    string       tag_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    logic [31:0] m_exp, m_act;
    bit          m_kind;
    string       m_tag;

    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            m_exp  = exp_q.pop_front();
            m_kind = kind_q.pop_front();
            m_tag  = tag_q.pop_front();
            m_act  = m_kind ? {31'b0, irq_out} : bus_rdata;
            n_cmp++;
            if (m_act !== m_exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", m_tag, m_act, m_exp);
            end
        end
    end

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        exp_q.push_back(e);
        kind_q.push_back(1'b0);
        tag_q.push_back(t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        bus_wr = 1'b0;
        exp_q.push_back({31'b0, e});
        kind_q.push_back(1'b1);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic wr_pins(input logic [7:0] a, input logic [31:0] d, input logic [7:0] p);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        pin_in    = p;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        bus_wr = 1'b0;
        pin_in = p;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        chk(A_STS, 32'h0, "R1 status in reset");
        chk(A_EN,  32'h0, "R1 enable in reset");
        chk(A_TYP, 32'h0, "R1 type in reset");
        chk_irq(1'b0, "R1 irq in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R6: default type is low level, pins low
        chk(A_STS, 32'hFF, "R6 low level after reset");
        chk_irq(1'b0, "R9 no enable no irq");
        set_pins(8'h0F);
        chk(A_STS, 32'hF0, "R6 low level follows pins");
        wr(A_CLR, 32'hFF);
        chk(A_STS, 32'hF0, "R6 clear ignored while level holds");

        // Pins 0..3 to high level
        wr(A_TYP, 32'h0000000F);
        chk(A_STS, 32'hF0, "R10 type change clears status");
        chk(A_STS, 32'hFF, "R6 high level follows pins");

        // R8 / R9: enable and masked alias
        wr(A_EN, 32'h01);
        chk(A_EN, 32'h01, "R8 full enable write");
        chk_irq(1'b1, "R9 irq on enabled status");
        wr(A_MSK, 32'h8080);
        chk(A_EN, 32'h81, "R8 masked set keeps bit0");
        wr(A_MSK, 32'h0100);
        chk(A_EN, 32'h80, "R8 masked clear bit0");
        wr(A_MSK, 32'h00FF);
        chk(A_EN, 32'h80, "R8 zero mask changes nothing");
        chk_irq(1'b1, "R9 irq from pin7");
        wr(A_EN, 32'h00);
        chk_irq(1'b0, "R9 irq off when disabled");

        // R2: pin0 rising, pin1 falling, pin2 both, pin3 high, 4..7 low
        wr(A_TYP, 32'h00040709);
        chk(A_STS, 32'hF8, "R10 changed pins cleared, unchanged kept");
        chk(A_TYP, 32'h00040709, "R2 type readback");
        set_pins(8'h08);
        chk(A_STS, 32'hFE, "R4 R5 fall sets falling and both, R3 rising ignores fall");
        wr(A_CLR, 32'h06);
        chk(A_STS, 32'hF8, "R7 clear edge status");
        set_pins(8'h0F);
        chk(A_STS, 32'hFD, "R3 R5 rise sets rising and both, R4 falling ignores rise");
        set_pins(8'h08);
        chk(A_STS, 32'hFF, "R7 sticky pin0, R4 fall again");
        wr_pins(A_CLR, 32'h01, 8'h09);
        chk(A_STS, 32'hFF, "R7 edge wins over same-cycle clear");
        wr(A_CLR, 32'h00);
        chk(A_STS, 32'hFF, "R7 zero clear bits no effect");
        wr(A_CLR, 32'h07);
        chk(A_STS, 32'hF8, "R7 clear three edge bits");

        // R11: read-only status, zero reads
        wr(A_STS, 32'h00);
        chk(A_STS, 32'hF8, "R11 status ignores writes");
        chk(8'h10, 32'h0, "R11 unmapped reads zero");
        chk(A_CLR, 32'h0, "R11 clear register reads zero");

        // R10: no false edge right after a type change (pin5 to rising)
        wr(A_TYP, 32'h00042729);
        set_pins(8'h29);
        chk(A_STS, 32'hD8, "R10 no false edge after type change");
        set_pins(8'h09);
        set_pins(8'h29);
        chk(A_STS, 32'hF8, "R3 real rise after rearm");

        // R9 / R7: interrupt from an edge, removed by clear
        wr(A_EN, 32'h20);
        chk_irq(1'b1, "R9 irq from edge status");
        wr(A_CLR, 32'h20);
        chk_irq(1'b0, "R7 R9 clear drops irq");
        chk(A_STS, 32'hD8, "R7 status after clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule